// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a 24-bit control word into an external frequency synthesizer over two wires, a serial clock and a serial data line. A requester presents the word and pulses a start input while the block is idle. The block takes a copy of the word and raises busy. It then plays out a fixed series of line states, and every state holds for a programmable number of system clocks.

The series has four parts. First comes an unlock run of clock pulses with the data line held high. Next comes a start bit. The word follows, least significant bit first, and each bit is sent as four states: the data line first carries the complement of the bit and then its true value. A stop bit closes the series. When the last state ends, the block drops busy and pulses done. If the word addressed one of the three video clock registers, it also moves a two-bit clock-select output to that register number.

Select codes that name no register are flagged on an error output. The word is still sent in that case.

Top module: `freq_synth_loader`

## Requirements
- R1: After reset, syn_clk_o, syn_data_o, busy_o, done_o and err_o are 0 and sel_o is 2'b00. Whenever busy_o is low, both serial lines are low.
- R2: A start_i sampled high while busy_o is low captures word_i and raises busy_o at that edge. From that edge on, each line state holds for exactly PHASE_CLKS clock cycles.
- R3: The first 10 states form the unlock run. They are five pulses, each made of (clk 0, data 1) followed by (clk 1, data 1).
- R4: The next four states form the start bit: (0,0), (1,0), (0,0), (1,0), written as (clk, data).
- R5: Data bits go out in order from word bit 0 to word bit 23. Each bit b takes four states: (1, not b), (0, not b), (0, b), (1, b). The data line never changes in a cycle in which the clock line rises.
- R6: After bit 23 come three stop states: (1,1), (0,1), (1,1).
- R7: At the edge that ends the last stop state, busy_o falls and both lines return low. done_o is high for exactly that one following cycle.
- R8: If bits 23:21 of the captured word hold 0, 1 or 2, sel_o takes bits 22:21 at the edge where done_o rises.
- R9: For select codes 3, 4, 5, 6 and 7, sel_o keeps the value it held before the transfer. sel_o never changes while busy_o is high.
- R10: err_o is updated at each accepted start. It is 1 when bits 23:21 of the word are 5 or 7 and 0 otherwise, and it holds that value until the next accepted start.
- R11: A start_i pulse while busy_o is high has no effect on the line sequence, the word being sent or the select result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Transfer request, sampled when idle |
| word_i | input | WORD_W (24) | Control word; bits 23:21 select the register |
| busy_o | output | 1 | High while a transfer is running |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| err_o | output | 1 | Last accepted word had an illegal select code |
| syn_clk_o | output | 1 | Serial clock line to the synthesizer |
| syn_data_o | output | 1 | Serial data line to the synthesizer |
| sel_o | output | 2 | Clock-select lines for the video clock registers |

## Verification
Two events can fall in the same cycle: the end of one transfer and a request for the next. A request in the last cycle of the final stop state sees busy_o still high, so it must be dropped. A request in the done_o cycle sees busy_o low, so it must start a new transfer at once. The bench issues both kinds back to back. It judges the result by checking the full line sequence of the following transfer state by state, and by checking that sel_o and err_o follow only the accepted word.

// File: rtl/fsl_pkg.sv
// Shared types and helpers for the synthesizer serial programmer.
// Assumes the select field is three bits wide.
package fsl_pkg;

    // Levels of the two serial lines during one state
    typedef struct packed {
        logic clk;
        logic dat;
    } line_lvl_t;

    // Codes 5 and 7 address no register in the synthesizer
    function automatic logic sel_is_illegal(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd7);
    endfunction

endpackage

// File: rtl/fsl_phase_timer.sv
// Phase timer: measures the length of one line state in system clocks.
// Assumes restart is raised only while run is low.
module fsl_phase_timer #(
    parameter int PHASE_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles inside the current state and wrap at its last cycle
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (run)          cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == CNT_LAST);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

endmodule

// File: rtl/fsl_wave_map.sv
// Wave map: turns a state index and the bit being sent into line levels.
// Assumes the layout unlock, start, data, stop with an even unlock length.
module fsl_wave_map
    import fsl_pkg::*;
#(
    parameter int WORD_W        = 24,
    parameter int UNLOCK_PULSES = 5,
    parameter int PW            = 7
) (
    input  logic [PW-1:0] phase,
    input  logic          bit_i,
    output line_lvl_t     lvl
);
    localparam int UNL_PH    = 2 * UNLOCK_PULSES;
    localparam int DATA_BASE = UNL_PH + 4;
    localparam int STOP_BASE = DATA_BASE + 4 * WORD_W;

    logic [PW-1:0] off_start;
    logic [PW-1:0] off_data;
    logic [1:0]    sub;

    assign off_start = phase - PW'(UNL_PH);
    assign off_data  = phase - PW'(DATA_BASE);
    assign sub       = off_data[1:0];

    // Decode the line levels of the given state
    always_comb begin
        if (phase < PW'(UNL_PH)) begin
            lvl.clk = phase[0];
            lvl.dat = 1'b1;
        end else if (phase < PW'(DATA_BASE)) begin
            lvl.clk = off_start[0];
            lvl.dat = 1'b0;
        end else if (phase < PW'(STOP_BASE)) begin
            lvl.clk = (sub == 2'd0) || (sub == 2'd3);
            lvl.dat = sub[1] ? bit_i : ~bit_i;
        end else begin
            lvl.clk = (phase != PW'(STOP_BASE + 1));
            lvl.dat = 1'b1;
        end
    end

endmodule

// File: rtl/fsl_sel_ctrl.sv
// Select control: keeps the register code of the current word, reports
// illegal codes and moves the clock-select lines when a transfer ends.
// Assumes accept and finish never occur in the same cycle.
module fsl_sel_ctrl
    import fsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [2:0] code_in,
    input  logic       finish,
    output logic [1:0] sel_o,
    output logic       err_o
);
    logic [2:0] code_q;

    // Capture the code and its legality when a transfer is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            err_o  <= 1'b0;
        end else if (accept) begin
            code_q <= code_in;
            err_o  <= sel_is_illegal(code_in);
        end
    end

    // Drive the select lines at the end of a video clock transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                          sel_o <= 2'b00;
        else if (finish && code_q <= 3'd2)   sel_o <= code_q[1:0];
    end

    // R8
    sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && code_q <= 3'd2) |=> (sel_o == $past(code_q[1:0])));

    // R9
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && code_q > 3'd2) |=> $stable(sel_o));

    // R10
    err_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o != $past(err_o)) |-> $past(accept));

endmodule

// File: rtl/freq_synth_loader.sv
// Synthesizer serial programmer top. Accepts a control word on start,
// plays out unlock, start bit, data bits and stop bit on two registered
// lines, then updates the clock-select lines. Assumes PHASE_CLKS >= 1.
module freq_synth_loader
    import fsl_pkg::*;
#(
    parameter int PHASE_CLKS    = 8,
    parameter int WORD_W        = 24,
    parameter int UNLOCK_PULSES = 5,
    parameter int SEL_LSB       = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              syn_clk_o,
    output logic              syn_data_o,
    output logic [1:0]        sel_o
);
    localparam int UNL_PH    = 2 * UNLOCK_PULSES;
    localparam int DATA_BASE = UNL_PH + 4;
    localparam int STOP_BASE = DATA_BASE + 4 * WORD_W;
    localparam int LAST_PH   = STOP_BASE + 2;
    localparam int PW        = $clog2(LAST_PH + 1);

    logic              busy_q, done_q;
    logic [PW-1:0]     ph_q, ph_nxt;
    logic [WORD_W-1:0] sh_q, sh_nxt;
    line_lvl_t         lvl_q, lvl_nxt;
    logic              tick, accept, finish, in_data;
    logic [PW-1:0]     off_data;

    assign accept   = start_i && !busy_q;
    assign finish   = busy_q && tick && (ph_q == PW'(LAST_PH));
    assign off_data = ph_q - PW'(DATA_BASE);
    assign in_data  = (ph_q >= PW'(DATA_BASE)) && (ph_q < PW'(STOP_BASE));

    fsl_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy_q), .tick(tick)
    );

    // Next state index and shift register contents
    always_comb begin
        ph_nxt = ph_q;
        sh_nxt = sh_q;
        if (accept) begin
            ph_nxt = '0;
            sh_nxt = word_i;
        end else if (busy_q && tick && !finish) begin
            ph_nxt = ph_q + 1'b1;
            if (in_data && off_data[1:0] == 2'd3) sh_nxt = sh_q >> 1;
        end
    end

    fsl_wave_map #(.WORD_W(WORD_W), .UNLOCK_PULSES(UNLOCK_PULSES), .PW(PW)) u_map (
        .phase(ph_nxt), .bit_i(sh_nxt[0]), .lvl(lvl_nxt)
    );

    // Sequencer registers and registered line outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ph_q   <= '0;
            sh_q   <= '0;
            lvl_q  <= '0;
        end else begin
            busy_q <= accept ? 1'b1 : (finish ? 1'b0 : busy_q);
            done_q <= finish;
            ph_q   <= ph_nxt;
            sh_q   <= sh_nxt;
            lvl_q  <= (accept || (busy_q && !finish)) ? lvl_nxt : '0;
        end
    end

    fsl_sel_ctrl u_sel (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .code_in(word_i[SEL_LSB+2:SEL_LSB]), .finish(finish),
        .sel_o(sel_o), .err_o(err_o)
    );

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign syn_clk_o  = lvl_q.clk;
    assign syn_data_o = lvl_q.dat;

    // R1
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!syn_clk_o && !syn_data_o));

    // R5
    data_steady_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_clk_o) |-> $stable(syn_data_o));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    sel_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sel_o));

    // R11
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && !finish) |=> busy_q);

endmodule

// File: tb/freq_synth_loader_tb.sv
// Bench: sends words that cover every select code and several bit patterns,
// compares every cycle of every line state against a sequence built here.
module freq_synth_loader_tb;
    localparam int PH   = 3;
    localparam int NPH  = 10 + 4 + 4 * 24 + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] word_i = '0;
    logic        busy_o, done_o, err_o, syn_clk_o, syn_data_o;
    logic [1:0]  sel_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_sel = 2'b00;
    logic       exp_err = 1'b0;
    logic       exp_c [NPH];
    logic       exp_d [NPH];

    always #10 clk = ~clk;

    freq_synth_loader #(.PHASE_CLKS(PH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .syn_clk_o(syn_clk_o), .syn_data_o(syn_data_o), .sel_o(sel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Build the expected line sequence for one word
    task automatic build(input logic [23:0] w);
        int n = 0;
        for (int i = 0; i < 5; i++) begin
            exp_c[n] = 0; exp_d[n] = 1; n++;
            exp_c[n] = 1; exp_d[n] = 1; n++;
        end
        for (int i = 0; i < 2; i++) begin
            exp_c[n] = 0; exp_d[n] = 0; n++;
            exp_c[n] = 1; exp_d[n] = 0; n++;
        end
        for (int b = 0; b < 24; b++) begin
            exp_c[n] = 1; exp_d[n] = !w[b]; n++;
            exp_c[n] = 0; exp_d[n] = !w[b]; n++;
            exp_c[n] = 0; exp_d[n] = w[b];  n++;
            exp_c[n] = 1; exp_d[n] = w[b];  n++;
        end
        exp_c[n] = 1; exp_d[n] = 1; n++;
        exp_c[n] = 0; exp_d[n] = 1; n++;
        exp_c[n] = 1; exp_d[n] = 1;
    endtask

    // One transfer, entered and left at a falling edge; poke adds ignored starts
    task automatic run(input logic [23:0] w, input bit poke);
        logic [2:0] code = w[23:21];
        build(w);
        start_i = 1'b1;
        word_i  = w;
        @(negedge clk);
        start_i = 1'b0;
        exp_err = (code == 3'd5) || (code == 3'd7);
        for (int k = 0; k < NPH; k++) begin
            for (int c = 0; c < PH; c++) begin
                chk("R3/R4/R5/R6 clk line", 32'(syn_clk_o), 32'(exp_c[k]));
                chk("R3/R4/R5/R6 data line", 32'(syn_data_o), 32'(exp_d[k]));
                chk("R2 busy", 32'(busy_o), 32'd1);
                chk("R10 err", 32'(err_o), 32'(exp_err));
                chk("R9 sel quiet while busy", 32'(sel_o), 32'(exp_sel));
                // R11: requests while busy, including the last cycle
                if (poke && ((k == 40 && c == 1) || (k == NPH - 1 && c == PH - 1))) begin
                    start_i = 1'b1;
                    word_i  = ~w;
                end else begin
                    start_i = 1'b0;
                    word_i  = w;
                end
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        if (code <= 3'd2) exp_sel = code[1:0];
        chk("R7 busy low", 32'(busy_o), 32'd0);
        chk("R7 done", 32'(done_o), 32'd1);
        chk("R7 lines low", {30'd0, syn_clk_o, syn_data_o}, 32'd0);
        chk("R8/R9 sel", 32'(sel_o), 32'(exp_sel));
        chk("R10 err held", 32'(err_o), 32'(exp_err));
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [20:0] pat [8];
        logic [2:0]  codes [8];
        pat[0] = 21'h155555; pat[1] = 21'h0AAAAA; pat[2] = 21'h1FFFFF; pat[3] = 21'h000000;
        pat[4] = 21'h0F0F31; pat[5] = 21'h13579B; pat[6] = 21'h1C3A5E; pat[7] = 21'h000001;
        codes[0] = 3'd1; codes[1] = 3'd5; codes[2] = 3'd2; codes[3] = 3'd7;
        codes[4] = 3'd3; codes[5] = 3'd0; codes[6] = 3'd6; codes[7] = 3'd4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset clk", 32'(syn_clk_o), 32'd0);
        chk("R1 reset data", 32'(syn_data_o), 32'd0);
        chk("R1 reset busy", 32'(busy_o), 32'd0);
        chk("R1 reset done", 32'(done_o), 32'd0);
        chk("R1 reset err", 32'(err_o), 32'd0);
        chk("R1 reset sel", 32'(sel_o), 32'd0);
        for (int i = 0; i < 8; i++) run({codes[i], pat[i]}, i[0]);
        // Back-to-back pair: code 2 then code 3 must leave sel at 2
        run({3'd2, 21'h0ABCDE}, 1'b1);
        run({3'd3, 21'h1234F0}, 1'b0);
        @(negedge clk);
        chk("R7 done single cycle", 32'(done_o), 32'd0);
        chk("R1 idle lines", {30'd0, syn_clk_o, syn_data_o}, 32'd0);
        chk("R9 sel kept after code 3", 32'(sel_o), 32'd2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule